// File: doc/BRIEF.md
# SMBus Alert Latch with Two-Step Clear

This block drives the active-low alert line of a temperature-monitoring SMBus slave. Each fault condition arrives as a level. While alerts are unmasked, any active fault pulls the alert line low, and the line stays low after the fault goes away. The bus master releases the alert with two reads in order. First it reads the status register. Then it issues a read to the Alert Response Address (ARA). If a fault is still active and unmasked when that ARA read completes, the line stays low.

A per-fault sticky status vector records every fault event, including events that arrive while the mask is set. When the master reads the status register, each bit clears unless its fault is still present in that cycle. During an ARA read the block raises a respond flag, and only while its own alert is asserted. This flag tells the external byte engine to return this device's 7-bit address followed by a 0 bit. The byte engine, arbitration on the wire and the temperature measurement are outside the block. They appear here as one-cycle read strobes and fault levels.

Top module: `smbus_alert_latch`

## Requirements
- R1: While reset is active, and in the first cycles after it, `alert_no` is 1 and `status_o` is all zero. Reset also clears the record of a status read, so an ARA read issued straight after reset clears nothing.
- R2: If any `fault_i` bit is 1 and `mask_i` is 0 at a rising clock edge, `alert_no` is 0 after that edge.
- R3: Once asserted, the alert is released only by an ARA read when a status read has come before it. `alert_no` returns to 1 after the edge that samples the ARA strobe.
- R4: A status read that no ARA read follows leaves `alert_no` at 0, however many cycles pass.
- R5: An ARA read with no status read since the previous ARA read (or since reset) leaves `alert_no` at 0.
- R6: Setting `mask_i` while the alert is asserted does not release it.
- R7: While `mask_i` is 1, a fault does not assert the alert. Its status bit is still set.
- R8: If an unmasked fault is active in the cycle of a releasing ARA read, `alert_no` stays 0.
- R9: Status bit i goes to 1 after any edge where `fault_i[i]` is 1. It holds until an edge with a status read, after which it equals `fault_i[i]` as sampled at that edge.
- R10: `ara_ack_o` is 1 exactly when `ara_rd_i` is 1 and the alert is asserted. `ara_byte_o` is always {SLAVE_ADDR, 1'b0}, which is 8'h98 for the default address 7'h4C.
- R11: Each status read allows only one release. An ARA read uses up the pending status read, so a later alert needs a new status read before an ARA read can release it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| fault_i | input | NUM_FAULTS | Fault condition levels, one per source |
| stat_rd_i | input | 1 | One-cycle strobe: the master read the status register |
| ara_rd_i | input | 1 | One-cycle strobe: the master issued an ARA read |
| mask_i | input | 1 | Configuration bit; 1 keeps new faults from asserting the alert |
| alert_no | output | 1 | Alert line, 0 when asserted |
| status_o | output | NUM_FAULTS | Sticky per-fault status bits |
| ara_ack_o | output | 1 | The device claims the current ARA read |
| ara_byte_o | output | 8 | Reply byte for the ARA read: slave address, then a 0 bit |

## Verification
The hardest states to reach from the ports are those where the order of reads goes wrong. Examples are an ARA read with no status read before it, a status read already used up by an earlier ARA read, and a releasing ARA read that lands while a fault is still active. Directed sequences set up each of these orderings on purpose, with the mask toggled between the two reads. After them, a long stretch of random strobes and sparse fault pulses is compared cycle by cycle against a behavioural model. This random stretch mixes reads, masks and faults in orders that the directed cases do not cover.

// File: rtl/smb_alert_pkg.sv
`timescale 1ns/1ps
package smb_alert_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BYTE_W = ADDR_W + 1;

  // Read-order tracker: whether a status read is waiting for an ARA read
  typedef enum logic {
    PH_IDLE      = 1'b0,
    PH_STAT_SEEN = 1'b1
  } rd_phase_e;

  // Reply byte placed on the bus for an ARA read: address, then a 0 bit
  function automatic logic [BYTE_W-1:0] ara_reply(input logic [ADDR_W-1:0] addr);
    return {addr, 1'b0};
  endfunction
endpackage

// File: rtl/smb_alert_rst_sync.sv
`timescale 1ns/1ps
// Asserts reset asynchronously and releases it on a clock edge
module smb_alert_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb pipe_d = 1'b1;
    end else begin : g_many
      always_comb pipe_d = {pipe_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign rst_no = pipe_q[STAGES-1];
endmodule

// File: rtl/smb_alert_status.sv
`timescale 1ns/1ps
// Sticky per-fault status bits, cleared on a status read unless the fault persists
module smb_alert_status #(
  parameter int unsigned NUM_FAULTS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_FAULTS-1:0] fault_i,
  input  logic                  stat_rd_i,
  output logic [NUM_FAULTS-1:0] status_o
);
  logic [NUM_FAULTS-1:0] stat_q;
  logic [NUM_FAULTS-1:0] stat_d;
  logic [NUM_FAULTS-1:0] stat_en;

  for (genvar g = 0; g < NUM_FAULTS; g++) begin : g_bit
    always_comb begin
      stat_en[g] = stat_rd_i | fault_i[g];
      stat_d[g]  = fault_i[g] | (stat_q[g] & ~stat_rd_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stat_q[g] <= 1'b0;
      end else if (stat_en[g]) begin
        stat_q[g] <= stat_d[g];
      end
    end
  end

  assign status_o = stat_q;
endmodule

// File: rtl/smb_alert_seq.sv
`timescale 1ns/1ps
// Alert latch plus the status-then-ARA release sequencer
module smb_alert_seq
  import smb_alert_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_any_i,
  input  logic mask_i,
  input  logic stat_rd_i,
  input  logic ara_rd_i,
  output logic alert_o,
  output logic stat_seen_o
);
  rd_phase_e phase_q, phase_d;
  logic      alert_q, alert_d;
  logic      raise, release_hit;

  always_comb begin
    phase_d = phase_q;
    if (stat_rd_i) begin
      phase_d = PH_STAT_SEEN;
    end else if (ara_rd_i) begin
      phase_d = PH_IDLE;
    end
  end

  always_comb begin
    raise       = fault_any_i & ~mask_i;
    release_hit = ara_rd_i & (phase_q == PH_STAT_SEEN) & alert_q;
    alert_d     = raise | (alert_q & ~release_hit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      alert_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      alert_q <= alert_d;
    end
  end

  assign alert_o     = alert_q;
  assign stat_seen_o = (phase_q == PH_STAT_SEEN);
endmodule

// File: rtl/smbus_alert_latch.sv
`timescale 1ns/1ps
module smbus_alert_latch
  import smb_alert_pkg::*;
#(
  parameter int unsigned NUM_FAULTS  = 4,
  parameter logic [6:0]  SLAVE_ADDR  = 7'h4C,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_FAULTS-1:0] fault_i,
  input  logic                  stat_rd_i,
  input  logic                  ara_rd_i,
  input  logic                  mask_i,
  output logic                  alert_no,
  output logic [NUM_FAULTS-1:0] status_o,
  output logic                  ara_ack_o,
  output logic [BYTE_W-1:0]     ara_byte_o
);
  logic rst_sync_n;
  logic fault_any;
  logic alert_q;
  logic stat_seen;

  smb_alert_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  smb_alert_status #(.NUM_FAULTS(NUM_FAULTS)) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .fault_i   (fault_i),
    .stat_rd_i (stat_rd_i),
    .status_o  (status_o)
  );

  assign fault_any = |fault_i;

  smb_alert_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .fault_any_i (fault_any),
    .mask_i      (mask_i),
    .stat_rd_i   (stat_rd_i),
    .ara_rd_i    (ara_rd_i),
    .alert_o     (alert_q),
    .stat_seen_o (stat_seen)
  );

  assign alert_no   = ~alert_q;
  assign ara_ack_o  = ara_rd_i & alert_q;
  assign ara_byte_o = ara_reply(SLAVE_ADDR);
endmodule

// File: rtl/smbus_alert_latch_chk.sv
`timescale 1ns/1ps
module smbus_alert_latch_chk #(
  parameter int unsigned NUM_FAULTS = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_FAULTS-1:0] fault_i,
  input logic                  stat_rd_i,
  input logic                  ara_rd_i,
  input logic                  mask_i,
  input logic                  alert_no,
  input logic [NUM_FAULTS-1:0] status_o,
  input logic                  ara_ack_o,
  input logic                  stat_seen
);
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (alert_no && status_o == '0));

  a_r2_fault_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fault_i && !mask_i) |=> !alert_no);

  a_r3_release_needs_sequence: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alert_no && !(ara_rd_i && stat_seen)) |=> !alert_no);

  a_r4_stat_read_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alert_no && stat_rd_i && !ara_rd_i) |=> !alert_no);

  a_r7_mask_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alert_no && mask_i) |=> alert_no);

  a_r8_persist_reassert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alert_no && ara_rd_i && |fault_i && !mask_i) |=> !alert_no);

  a_r9_status_records: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |fault_i |=> ((status_o & $past(fault_i)) == $past(fault_i)));

  a_r10_ack_only_alerting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ara_ack_o |-> (ara_rd_i && !alert_no));

  a_r11_seen_consumed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ara_rd_i && !stat_rd_i) |=> !stat_seen);
endmodule

bind smbus_alert_latch smbus_alert_latch_chk #(.NUM_FAULTS(NUM_FAULTS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_sync_n),
  .fault_i   (fault_i),
  .stat_rd_i (stat_rd_i),
  .ara_rd_i  (ara_rd_i),
  .mask_i    (mask_i),
  .alert_no  (alert_no),
  .status_o  (status_o),
  .ara_ack_o (ara_ack_o),
  .stat_seen (stat_seen)
);

// File: tb/smbus_alert_latch_tb.sv
`timescale 1ns/1ps
module smbus_alert_latch_tb;
  localparam int NF = 4;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic [NF-1:0] fault;
  logic          stat_rd, ara_rd, mask;
  logic          alert_no, ara_ack;
  logic [NF-1:0] status;
  logic [7:0]    ara_byte;

  int checks = 0;
  int errors = 0;
  logic cmp_en = 1'b0;
  logic ack_pre;

  // Behavioural reference state
  logic          m_alert;
  logic          m_seen;
  logic [NF-1:0] m_status;

  always #4 clk = ~clk;

  smbus_alert_latch #(.NUM_FAULTS(NF), .SLAVE_ADDR(7'h4C), .SYNC_STAGES(2)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .fault_i    (fault),
    .stat_rd_i  (stat_rd),
    .ara_rd_i   (ara_rd),
    .mask_i     (mask),
    .alert_no   (alert_no),
    .status_o   (status),
    .ara_ack_o  (ara_ack),
    .ara_byte_o (ara_byte)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic nxt_alert;
    if (!rst_ni) begin
      m_alert  <= 1'b0;
      m_seen   <= 1'b0;
      m_status <= '0;
    end else begin
      nxt_alert = m_alert;
      if (ara_rd && m_seen) nxt_alert = 1'b0;
      if (fault != 0 && !mask) nxt_alert = 1'b1;
      m_alert  <= nxt_alert;
      m_status <= stat_rd ? fault : (m_status | fault);
      if (stat_rd) m_seen <= 1'b1;
      else if (ara_rd) m_seen <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R3 model alert_no", alert_no, !m_alert);
      chk("R9 model status", status, m_status);
      chk("R10 model ack", ara_ack, ara_rd & m_alert);
      chk("R10 model byte", ara_byte, 8'h98);
    end
  end

  // Called at a falling edge; drives for one cycle and returns at the next falling edge
  task automatic step(input logic [NF-1:0] f, input logic s, input logic a, input logic m);
    #1;
    fault = f; stat_rd = s; ara_rd = a; mask = m;
    #1;
    ack_pre = ara_ack;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic m);
    for (int i = 0; i < n; i++) step('0, 1'b0, 1'b0, m);
  endtask

  initial begin
    #1_600_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; fault = '0; stat_rd = 1'b0; ara_rd = 1'b0; mask = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 alert in reset", alert_no, 1'b1);
    chk("R1 status in reset", status, 4'h0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;
    chk("R1 alert after reset", alert_no, 1'b1);
    chk("R1 status after reset", status, 4'h0);

    // ARA with no alert: not claimed
    step('0, 1'b0, 1'b1, 1'b0);
    chk("R10 no ack when idle", ack_pre, 1'b0);

    // Fault pulse raises alert; ARA first, without status read
    step(4'b0010, 1'b0, 1'b0, 1'b0);
    chk("R2 alert raised", alert_no, 1'b0);
    chk("R9 status set", status, 4'b0010);
    idle(2, 1'b0);
    chk("R9 status sticky", status, 4'b0010);
    step('0, 1'b0, 1'b1, 1'b0);
    chk("R10 ack while alerting", ack_pre, 1'b1);
    chk("R10 reply byte", ara_byte, 8'h98);
    chk("R5 ARA alone holds", alert_no, 1'b0);
    chk("R1 reset cleared read record", alert_no, 1'b0);
    step('0, 1'b1, 1'b0, 1'b0);
    chk("R9 status cleared by read", status, 4'b0000);
    idle(3, 1'b0);
    chk("R4 status read alone holds", alert_no, 1'b0);
    idle(2, 1'b1);
    chk("R6 mask does not clear", alert_no, 1'b0);
    step('0, 1'b0, 1'b1, 1'b0);
    chk("R3 released by sequence", alert_no, 1'b1);

    // Masked fault: recorded but no alert
    step(4'b0100, 1'b0, 1'b0, 1'b1);
    chk("R7 masked fault no alert", alert_no, 1'b1);
    chk("R7 masked fault recorded", status, 4'b0100);
    idle(2, 1'b0);
    chk("R7 still quiet after unmask", alert_no, 1'b1);
    step('0, 1'b1, 1'b0, 1'b0);
    chk("R9 clear after read", status, 4'b0000);
    step('0, 1'b0, 1'b1, 1'b0);

    // Persisting fault at release
    step(4'b0001, 1'b0, 1'b0, 1'b0);
    step(4'b0001, 1'b1, 1'b0, 1'b0);
    chk("R9 read keeps live bit", status, 4'b0001);
    step(4'b0001, 1'b0, 1'b1, 1'b0);
    chk("R8 persisting fault holds alert", alert_no, 1'b0);
    step('0, 1'b1, 1'b0, 1'b0);
    chk("R9 cleared when fault gone", status, 4'b0000);
    step('0, 1'b0, 1'b1, 1'b0);
    chk("R8 releases once fault gone", alert_no, 1'b1);

    // Status read is used up by one ARA read
    step(4'b1000, 1'b0, 1'b0, 1'b0);
    step('0, 1'b1, 1'b0, 1'b0);
    step('0, 1'b0, 1'b1, 1'b0);
    chk("R11 first release", alert_no, 1'b1);
    step(4'b1000, 1'b0, 1'b0, 1'b0);
    chk("R2 alert raised again", alert_no, 1'b0);
    step('0, 1'b0, 1'b1, 1'b0);
    chk("R11 consumed read gives no release", alert_no, 1'b0);
    step('0, 1'b1, 1'b0, 1'b0);
    step('0, 1'b0, 1'b1, 1'b0);
    chk("R11 fresh read releases", alert_no, 1'b1);

    // Random mix against the model
    for (int i = 0; i < 600; i++) begin
      logic [NF-1:0] f;
      f = ($urandom % 8 == 0) ? NF'($urandom) : '0;
      step(f, ($urandom % 5) == 0, ($urandom % 4) == 0, ($urandom % 6) == 0);
    end
    idle(2, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule